// File: doc/BRIEF.md
# Accumulator Processor Core with Shared 16-Byte Memory

This block is a small 8-bit processor built around a single accumulator. Program and data share one internal memory of sixteen bytes. Every instruction is one byte. The upper nibble selects the operation and the lower nibble names the memory location it works on. A multi-cycle sequencer moves each value through explicit registers:

- The program counter goes to the memory address register, which addresses the RAM.
- The RAM output is captured in the memory data register and copied into the instruction register.
- The instruction's address field goes back into the memory address register.
- The operand is captured in the memory data register and then reaches the accumulator or the adder.

While reset is held, a simple write port loads a program image into the memory. After reset is released, execution starts at address 0. Each instruction takes the same five cycles, in the states FETCH_ADDR → FETCH_DATA → DECODE → OPER_ADDR → EXECUTE. From EXECUTE the sequencer returns to FETCH_ADDR. After a halt instruction it goes instead to HALTED and stays there until reset. In DECODE the instruction byte is split: the opcode is latched into the instruction register and the address nibble is loaded into the memory address register. The program counter, accumulator, carry and halt status are brought out so that a program's effect can be observed.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `pc_dbg`=0, `acc_dbg`=0, `carry`=0 and `halted`=0, and the sequencer restarts in FETCH_ADDR.
- R2: A write through `load_we`/`load_addr`/`load_data` stores into RAM only at a rising edge where `rst` is high. A write attempted while running leaves the memory unchanged.
- R3: An instruction byte carries the opcode in bits [7:4] and the operand address in bits [3:0]. The opcodes are 0x0 no-op, 0x1 load, 0x2 add, 0x3 store and 0xF halt.
- R4: Every instruction occupies exactly five clock cycles. Its effect on `pc_dbg`, `acc_dbg` and `carry` appears at the fifth rising edge after its fetch began. The first fetch after reset reads address 0.
- R5: Load (0x1) copies the addressed byte into the accumulator.
- R6: Add (0x2) sets the accumulator to (acc + mem[addr]) mod 256 and sets `carry` to bit 8 of the full sum. No other instruction changes `carry`.
- R7: Store (0x3) writes the accumulator into the addressed location. A later load from that location returns the stored value.
- R8: After every instruction other than halt, the PC increments by one and wraps from 15 to 0.
- R9: Halt (0xF) raises `halted` at the end of its EXECUTE cycle and leaves the PC on the halt instruction. From then on, `pc_dbg`, `acc_dbg`, `carry` and `halted` hold until reset.
- R10: The opcodes 0x4 to 0xE act as no-ops. They change nothing but the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also enables preloading |
| load_we | input | 1 | Preload write strobe, honoured only in reset |
| load_addr | input | 4 | Preload memory location |
| load_data | input | 8 | Preload byte |
| halted | output | 1 | High once a halt instruction has executed |
| carry | output | 1 | Carry out of the most recent add |
| pc_dbg | output | 4 | Current program counter |
| acc_dbg | output | 8 | Current accumulator |

## Verification
The bench aims at five corner cases.

- **Cycle timing.** It checks the exact edge at which the first instruction completes. A sequencer that is one state short or long would move the PC one cycle early or late.
- **Add overflow.** It drives adds that overflow to exactly 0x100 and to 0x110. A design that drops the ninth sum bit, or that clears carry on a load, would show a wrong `carry`.
- **Store and preload.** A store is followed by a load from the same location. Between them, a preload write is attempted while the core runs. A memory that missed the store, or accepted the stray write, would put the wrong sum in the accumulator.
- **PC wrap and unused opcodes.** It runs past address 15 and executes undefined opcodes. A design that saturates the PC, or treats an undefined code as a load, would diverge from the model.
- **Halt.** It keeps clocking after halt. A design that advances the PC past halt, or keeps sequencing, would show a changing PC.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int CPU_DATA_W = 8;
    localparam int CPU_ADDR_W = 4;
    localparam int CPU_OP_W   = CPU_DATA_W - CPU_ADDR_W;

    localparam logic [CPU_OP_W-1:0] OP_NOP   = 4'h0;
    localparam logic [CPU_OP_W-1:0] OP_LOAD  = 4'h1;
    localparam logic [CPU_OP_W-1:0] OP_ADD   = 4'h2;
    localparam logic [CPU_OP_W-1:0] OP_STORE = 4'h3;
    localparam logic [CPU_OP_W-1:0] OP_HALT  = 4'hF;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR,
        ST_FETCH_DATA,
        ST_DECODE,
        ST_OPER_ADDR,
        ST_EXECUTE,
        ST_HALTED
    } cpu_state_e;

endpackage

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Read register doubles as the memory data register.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata_q <= cells[raddr];
        end
    end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);
    logic [DATA_W:0] wide;

    always_comb begin
        wide = {1'b0, lhs} + {1'b0, rhs};
        sum  = wide[DATA_W-1:0];
        cout = wide[DATA_W];
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int OP_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output cpu_state_e      state_q,
    output logic            mar_from_pc,
    output logic            mar_from_ir,
    output logic            mdr_load,
    output logic            ir_load,
    output logic            acc_load,
    output logic            acc_add,
    output logic            mem_store,
    output logic            pc_inc,
    output logic            is_halted
);
    cpu_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH_ADDR: state_d = ST_FETCH_DATA;
            ST_FETCH_DATA: state_d = ST_DECODE;
            ST_DECODE:     state_d = ST_OPER_ADDR;
            ST_OPER_ADDR:  state_d = ST_EXECUTE;
            ST_EXECUTE:    state_d = (opcode == OP_HALT) ? ST_HALTED : ST_FETCH_ADDR;
            ST_HALTED:     state_d = ST_HALTED;
            default:       state_d = ST_FETCH_ADDR;
        endcase
    end

    always_comb begin
        mar_from_pc = 1'b0;
        mar_from_ir = 1'b0;
        mdr_load    = 1'b0;
        ir_load     = 1'b0;
        acc_load    = 1'b0;
        acc_add     = 1'b0;
        mem_store   = 1'b0;
        pc_inc      = 1'b0;
        is_halted   = 1'b0;
        unique case (state_q)
            ST_FETCH_ADDR: mar_from_pc = 1'b1;
            ST_FETCH_DATA: mdr_load    = 1'b1;
            ST_DECODE: begin
                ir_load     = 1'b1;
                mar_from_ir = 1'b1;
            end
            ST_OPER_ADDR:  mdr_load    = 1'b1;
            ST_EXECUTE: begin
                acc_load  = (opcode == OP_LOAD);
                acc_add   = (opcode == OP_ADD);
                mem_store = (opcode == OP_STORE);
                pc_inc    = (opcode != OP_HALT);
            end
            ST_HALTED:     is_halted   = 1'b1;
            default:       is_halted   = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = CPU_DATA_W,
    parameter int ADDR_W = CPU_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic              halted,
    output logic              carry,
    output logic [ADDR_W-1:0] pc_dbg,
    output logic [DATA_W-1:0] acc_dbg
);
    localparam int OP_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic              cy_q;
    logic [DATA_W-1:0] mdr_q;

    cpu_state_e state_q;
    logic mar_from_pc, mar_from_ir, mdr_load, ir_load;
    logic acc_load, acc_add, mem_store, pc_inc, is_halted;

    logic [DATA_W-1:0] alu_sum;
    logic              alu_cout;

    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [DATA_W-1:0] ram_wdata;

    acc_cpu_ctrl #(.OP_W(OP_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .opcode      (ir_q[DATA_W-1 -: OP_W]),
        .state_q     (state_q),
        .mar_from_pc (mar_from_pc),
        .mar_from_ir (mar_from_ir),
        .mdr_load    (mdr_load),
        .ir_load     (ir_load),
        .acc_load    (acc_load),
        .acc_add     (acc_add),
        .mem_store   (mem_store),
        .pc_inc      (pc_inc),
        .is_halted   (is_halted)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .lhs  (acc_q),
        .rhs  (mdr_q),
        .sum  (alu_sum),
        .cout (alu_cout)
    );

    // Preload port owns the write side only while reset is held.
    always_comb begin
        ram_we    = rst ? load_we   : mem_store;
        ram_waddr = rst ? load_addr : mar_q;
        ram_wdata = rst ? load_data : acc_q;
    end

    acc_cpu_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .re      (mdr_load & ~rst),
        .raddr   (mar_q),
        .rdata_q (mdr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
            cy_q  <= 1'b0;
        end else begin
            if (mar_from_pc) mar_q <= pc_q;
            if (mar_from_ir) mar_q <= mdr_q[ADDR_W-1:0];
            if (ir_load)     ir_q  <= mdr_q;
            if (acc_load)    acc_q <= mdr_q;
            if (acc_add)     {cy_q, acc_q} <= {alu_cout, alu_sum};
            if (pc_inc)      pc_q  <= pc_q + 1'b1;
        end
    end

    assign halted  = is_halted;
    assign carry   = cy_q;
    assign pc_dbg  = pc_q;
    assign acc_dbg = acc_q;
endmodule

// File: rtl/acc_cpu_checker.sv
module acc_cpu_checker
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int OP_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input cpu_state_e        state,
    input logic [OP_W-1:0]   opcode,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] acc,
    input logic              carry,
    input logic              halted
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pc == '0 && acc == '0 && !carry && !halted));

    a_r4_acc_only_in_execute: assert property (@(posedge clk) disable iff (rst)
        (state != ST_EXECUTE) |=> $stable(acc));

    a_r6_carry_only_in_execute: assert property (@(posedge clk) disable iff (rst)
        (state != ST_EXECUTE) |=> $stable(carry));

    a_r8_pc_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXECUTE && opcode != OP_HALT) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

    a_r9_halt_holds: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc) && $stable(acc) && $stable(carry)));
endmodule

bind acc_cpu_core acc_cpu_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .OP_W   (DATA_W - ADDR_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .state  (state_q),
    .opcode (ir_q[DATA_W-1 -: DATA_W-ADDR_W]),
    .pc     (pc_dbg),
    .acc    (acc_dbg),
    .carry  (carry),
    .halted (halted)
);

// File: tb/acc_cpu_core_test.sv
module acc_cpu_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_we = 1'b0;
    logic [3:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic       halted, carry;
    logic [3:0] pc_dbg;
    logic [7:0] acc_dbg;

    int n_chk = 0;
    int n_bad = 0;
    bit armed = 1'b0;

    // reference model state
    logic [7:0] m [16];
    logic [3:0] mpc = '0;
    logic [7:0] macc = '0;
    logic       mc = 1'b0;
    logic       mh = 1'b0;
    int         ph = 0;
    logic [7:0] prog [16];

    always #2 clk = ~clk;

    acc_cpu_core uut (
        .clk       (clk),
        .rst       (rst),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data),
        .halted    (halted),
        .carry     (carry),
        .pc_dbg    (pc_dbg),
        .acc_dbg   (acc_dbg)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural model: one whole instruction on every fifth edge after reset.
    always @(posedge clk) begin
        logic [8:0] s;
        logic [3:0] a;
        if (rst) begin
            if (load_we) m[load_addr] = load_data;
            mpc = '0; macc = '0; mc = 1'b0; mh = 1'b0; ph = 0;
        end else if (!mh) begin
            ph++;
            if (ph == 5) begin
                ph = 0;
                a = m[mpc][3:0];
                case (m[mpc][7:4])
                    4'h1: macc = m[a];
                    4'h2: begin s = {1'b0, macc} + {1'b0, m[a]}; macc = s[7:0]; mc = s[8]; end
                    4'h3: m[a] = macc;
                    4'hF: mh = 1'b1;
                    default: ;
                endcase
                if (!mh) mpc = mpc + 4'd1;
            end
        end
        armed = 1'b1;
    end

    always @(negedge clk) begin
        if (armed) begin
            check("R8 pc_dbg vs model", pc_dbg, mpc);
            check("R5 acc_dbg vs model", acc_dbg, macc);
            check("R6 carry vs model", carry, mc);
            check("R9 halted vs model", halted, mh);
        end
    end

    task automatic boot();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            load_we = 1'b1; load_addr = 4'(i); load_data = prog[i];
            @(negedge clk);
        end
        load_we = 1'b0;
        @(negedge clk);
        check("R1 pc in reset", pc_dbg, 0);
        check("R1 halted in reset", halted, 0);
        check("R1 acc in reset", acc_dbg, 0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // Test A: load, add, store, reload, halt; stray preload while running.
        for (int i = 0; i < 16; i++) prog[i] = 8'h00;
        prog[0] = 8'h18; prog[1] = 8'h29; prog[2] = 8'h3A; prog[3] = 8'h1A; prog[4] = 8'hF0;
        prog[8] = 8'h02; prog[9] = 8'h03;
        boot();
        repeat (4) @(negedge clk);
        check("R4 pc before fifth edge", pc_dbg, 0);
        @(negedge clk);
        check("R4 pc after fifth edge", pc_dbg, 1);
        check("R5 load of 2", acc_dbg, 8'h02);
        load_we = 1'b1; load_addr = 4'h9; load_data = 8'h77;  // R2: must be ignored
        @(negedge clk);
        load_we = 1'b0;
        repeat (40) @(negedge clk);
        check("R7 store then reload gives 5", acc_dbg, 8'h05);
        check("R2 running write ignored (sum uses 3)", acc_dbg, 8'h05);
        check("R9 halted after halt", halted, 1);
        check("R9 pc stays on halt", pc_dbg, 4);

        // Test B: overflow, unused opcodes, carry held across load.
        for (int i = 0; i < 16; i++) prog[i] = 8'h00;
        prog[0] = 8'h1E; prog[1] = 8'h2F; prog[2] = 8'h50; prog[3] = 8'h2E;
        prog[4] = 8'h3D; prog[5] = 8'hA7; prog[6] = 8'h1D; prog[7] = 8'hF0;
        prog[14] = 8'hF0; prog[15] = 8'h20; prog[13] = 8'h55;
        boot();
        repeat (10) @(negedge clk);
        check("R6 F0+20 sum", acc_dbg, 8'h10);
        check("R6 F0+20 carry", carry, 1);
        repeat (5) @(negedge clk);
        check("R10 unused opcode keeps acc", acc_dbg, 8'h10);
        check("R3 pc after three instructions", pc_dbg, 3);
        repeat (5) @(negedge clk);
        check("R6 10+F0 wraps to 0", acc_dbg, 8'h00);
        repeat (40) @(negedge clk);
        check("R7 reload stored zero", acc_dbg, 8'h00);
        check("R6 carry kept through load", carry, 1);
        check("R9 halted at 7", pc_dbg, 7);

        // Test C: PC wrap over sixteen locations.
        for (int i = 0; i < 16; i++) prog[i] = 8'h00;
        prog[15] = 8'h1F;
        boot();
        repeat (90) @(negedge clk);
        check("R8 pc wrapped", pc_dbg, 2);
        check("R5 self-load at 15", acc_dbg, 8'h1F);
        check("R9 never halted", halted, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule